// File: doc/BRIEF.md
# Dual-Clock Bidirectional Mailbox with Lane Parity

This block passes single 36-bit words between two ports that run on unrelated clocks, one holding register for each direction. Port A deposits a word for port B, and port B deposits a word for port A. The receiving port sees a mail-present flag. The sending port sees a busy indication until the receiver has taken the word. Both flags cross between the clock domains through a toggle handshake with two-flop synchronizers. Only the toggle bits cross. The word itself stays stable in the writer's register while it is in flight.

Each word is four 9-bit lanes. In each lane, bits 7:0 are data and bit 8 is the parity bit. Each port checks the parity of the word it presents for writing and reports the result on an active-low error output. The check is passive: a word with bad parity is stored and delivered like any other word. On the read side, each port can substitute a freshly generated parity bit into every lane. Each port has its own odd/even select, used both to check its writes and to generate parity on its reads.

Top module: `xmb_pair`

## Requirements
- R1: After reset, both mail flags and both busy outputs are 0, and both read buses show all zeros while generation is off.
- R2: A write accepted on one port raises the mail flag at the other port within four of that port's clock cycles. The flag stays high until the word is read, and the read bus shows the written word.
- R3: An accepted write raises the writer's busy output on the next writer clock edge. A write issued while busy is high is ignored, and the stored word is unchanged.
- R4: A read with the mail flag high clears the flag on the next reader clock edge. The writer's busy output then falls within ten writer clock cycles.
- R5: Mail from port B to port A follows the same flag, busy and data behaviour as the A-to-B direction.
- R6: A read pulse while no mail is present leaves the mail flag low and the opposite writer's busy output low.
- R7: While a write enable is high, the port's active-low parity error output is 0 exactly when some lane's 9-bit exclusive-OR differs from that port's odd select (1 = odd, 0 = even). While the write enable is low, the output is 1.
- R8: A word with a parity error is still stored and delivered bit for bit when generation is off.
- R9: With generation on, each lane of the read bus keeps its 8 data bits. Its bit 8 becomes the exclusive-OR of those bits, further XORed with the reading port's odd select.
- R10: With generation off, the stored bit 8 of each lane passes to the read bus unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| a_wr_en | input | 1 | Port A write strobe to the A-to-B mailbox |
| a_wdata | input | 36 | Port A write word |
| a_rd_en | input | 1 | Port A read strobe for the B-to-A mailbox |
| a_rdata | output | 36 | Port A read word |
| a_mail | output | 1 | Mail waiting for port A |
| a_busy | output | 1 | A-to-B mailbox still holds an unread word |
| a_odd | input | 1 | Port A parity sense, 1 = odd |
| a_gen | input | 1 | Port A read parity generation enable |
| a_perr_n | output | 1 | Port A write parity error, active low |
| b_wr_en | input | 1 | Port B write strobe to the B-to-A mailbox |
| b_wdata | input | 36 | Port B write word |
| b_rd_en | input | 1 | Port B read strobe for the A-to-B mailbox |
| b_rdata | output | 36 | Port B read word |
| b_mail | output | 1 | Mail waiting for port B |
| b_busy | output | 1 | B-to-A mailbox still holds an unread word |
| b_odd | input | 1 | Port B parity sense, 1 = odd |
| b_gen | input | 1 | Port B read parity generation enable |
| b_perr_n | output | 1 | Port B write parity error, active low |

## Verification
The bench builds the block with its default parameters: four lanes of eight data bits and two synchronizer stages. It drives the two ports from clocks of 10 ns and 14 ns, so the edges of the two domains slide past each other and the handshake is exercised at many phase offsets. With two stages, a full round trip takes only a few cycles. This leaves room to attempt a write while the mailbox is busy, to read when no mail is present, and to sweep both parity senses with generation on and off in both directions.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  localparam int unsigned LANES_DEF   = 4;
  localparam int unsigned LANE_DW_DEF = 8;
  localparam int unsigned SYNC_DEF    = 2;
endpackage

// File: rtl/xmb_rst_sync.sv
module xmb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/xmb_sync.sv
module xmb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/xmb_channel.sv
module xmb_channel #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned SYNC   = 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic              busy,
  output logic [WORD_W-1:0] word,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  output logic              mail
);
  // writer side
  logic [WORD_W-1:0] data_q, data_d;
  logic              req_q, req_d;
  logic              ack_s;
  logic              wr_take;

  // reader side
  logic ack_q, ack_d;
  logic req_s;
  logic rd_take;

  xmb_sync #(.STAGES(SYNC)) u_ack_sync (
    .clk(wclk), .rst_n(wrst_n), .d(ack_q), .q(ack_s)
  );

  xmb_sync #(.STAGES(SYNC)) u_req_sync (
    .clk(rclk), .rst_n(rrst_n), .d(req_q), .q(req_s)
  );

  always_comb begin
    busy    = req_q ^ ack_s;
    wr_take = wr_en & ~busy;
    data_d  = wr_take ? wdata : data_q;
    req_d   = req_q ^ wr_take;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      data_q <= '0;
      req_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      req_q  <= req_d;
    end
  end

  always_comb begin
    mail    = req_s ^ ack_q;
    rd_take = rd_en & mail;
    ack_d   = rd_take ? req_s : ack_q;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) ack_q <= 1'b0;
    else         ack_q <= ack_d;
  end

  assign word = data_q;
endmodule

// File: rtl/xmb_parity_port.sv
module xmb_parity_port #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned LANE_DW = 8,
  localparam int unsigned LANE_W = LANE_DW + 1,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              odd_sel,
  input  logic              gen_en,
  input  logic              chk_en,
  input  logic [WORD_W-1:0] chk_data,
  input  logic [WORD_W-1:0] raw_rd,
  output logic [WORD_W-1:0] rd_data,
  output logic              err_n
);
  logic [LANES-1:0] lane_bad;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_DW-1:0] rd_bits;
    logic               gen_bit;
    assign rd_bits     = raw_rd[i*LANE_W +: LANE_DW];
    assign gen_bit     = (^rd_bits) ^ odd_sel;
    assign lane_bad[i] = (^chk_data[i*LANE_W +: LANE_W]) != odd_sel;
    assign rd_data[i*LANE_W +: LANE_DW] = rd_bits;
    assign rd_data[i*LANE_W + LANE_DW]  = gen_en ? gen_bit : raw_rd[i*LANE_W + LANE_DW];
  end

  assign err_n = ~(chk_en & (|lane_bad));
endmodule

// File: rtl/xmb_pair.sv
module xmb_pair #(
  parameter int unsigned LANES   = xmb_pkg::LANES_DEF,
  parameter int unsigned LANE_DW = xmb_pkg::LANE_DW_DEF,
  parameter int unsigned SYNC    = xmb_pkg::SYNC_DEF,
  localparam int unsigned WORD_W = LANES * (LANE_DW + 1)
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              a_wr_en,
  input  logic [WORD_W-1:0] a_wdata,
  input  logic              a_rd_en,
  output logic [WORD_W-1:0] a_rdata,
  output logic              a_mail,
  output logic              a_busy,
  input  logic              a_odd,
  input  logic              a_gen,
  output logic              a_perr_n,
  input  logic              b_wr_en,
  input  logic [WORD_W-1:0] b_wdata,
  input  logic              b_rd_en,
  output logic [WORD_W-1:0] b_rdata,
  output logic              b_mail,
  output logic              b_busy,
  input  logic              b_odd,
  input  logic              b_gen,
  output logic              b_perr_n
);
  logic              rst_a_s, rst_b_s;
  logic [WORD_W-1:0] mb_ab_word, mb_ba_word;

  xmb_rst_sync #(.STAGES(SYNC)) u_rst_a (.clk(clk_a), .arst_n(rst_n), .srst_n(rst_a_s));
  xmb_rst_sync #(.STAGES(SYNC)) u_rst_b (.clk(clk_b), .arst_n(rst_n), .srst_n(rst_b_s));

  xmb_channel #(.WORD_W(WORD_W), .SYNC(SYNC)) u_ch_ab (
    .wclk(clk_a), .wrst_n(rst_a_s), .wr_en(a_wr_en), .wdata(a_wdata),
    .busy(a_busy), .word(mb_ab_word),
    .rclk(clk_b), .rrst_n(rst_b_s), .rd_en(b_rd_en), .mail(b_mail)
  );

  xmb_channel #(.WORD_W(WORD_W), .SYNC(SYNC)) u_ch_ba (
    .wclk(clk_b), .wrst_n(rst_b_s), .wr_en(b_wr_en), .wdata(b_wdata),
    .busy(b_busy), .word(mb_ba_word),
    .rclk(clk_a), .rrst_n(rst_a_s), .rd_en(a_rd_en), .mail(a_mail)
  );

  xmb_parity_port #(.LANES(LANES), .LANE_DW(LANE_DW)) u_par_a (
    .odd_sel(a_odd), .gen_en(a_gen), .chk_en(a_wr_en), .chk_data(a_wdata),
    .raw_rd(mb_ba_word), .rd_data(a_rdata), .err_n(a_perr_n)
  );

  xmb_parity_port #(.LANES(LANES), .LANE_DW(LANE_DW)) u_par_b (
    .odd_sel(b_odd), .gen_en(b_gen), .chk_en(b_wr_en), .chk_data(b_wdata),
    .raw_rd(mb_ab_word), .rd_data(b_rdata), .err_n(b_perr_n)
  );
endmodule

// File: rtl/xmb_pair_chk.sv
module xmb_pair_chk #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned LANE_DW = 8,
  localparam int unsigned LANE_W = LANE_DW + 1,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input logic              clk_a,
  input logic              clk_b,
  input logic              rst_a_s,
  input logic              rst_b_s,
  input logic              a_wr_en,
  input logic              b_wr_en,
  input logic              a_rd_en,
  input logic              b_rd_en,
  input logic              a_busy,
  input logic              b_busy,
  input logic              a_mail,
  input logic              b_mail,
  input logic              a_perr_n,
  input logic              b_perr_n,
  input logic              a_gen,
  input logic              b_gen,
  input logic              a_odd,
  input logic              b_odd,
  input logic [WORD_W-1:0] a_rdata,
  input logic [WORD_W-1:0] b_rdata,
  input logic [WORD_W-1:0] mb_ab_word,
  input logic [WORD_W-1:0] mb_ba_word
);
  function automatic logic lanes_match(input logic [WORD_W-1:0] w, input logic odd);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++) ok &= ((^w[i*LANE_W +: LANE_W]) == odd);
    return ok;
  endfunction

  AST_BUSY_SET_A: assert property (@(posedge clk_a) disable iff (!rst_a_s)
    (a_wr_en && !a_busy) |=> a_busy); // R3
  AST_BUSY_SET_B: assert property (@(posedge clk_b) disable iff (!rst_b_s)
    (b_wr_en && !b_busy) |=> b_busy); // R5
  AST_HOLD_AB: assert property (@(posedge clk_a) disable iff (!rst_a_s)
    a_busy |=> $stable(mb_ab_word)); // R3
  AST_HOLD_BA: assert property (@(posedge clk_b) disable iff (!rst_b_s)
    b_busy |=> $stable(mb_ba_word)); // R5
  AST_MAIL_CLR_B: assert property (@(posedge clk_b) disable iff (!rst_b_s)
    (b_rd_en && b_mail) |=> !b_mail); // R4
  AST_MAIL_CLR_A: assert property (@(posedge clk_a) disable iff (!rst_a_s)
    (a_rd_en && a_mail) |=> !a_mail); // R5
  AST_MAIL_NEEDS_BUSY: assert property (@(posedge clk_b) disable iff (!rst_b_s || !rst_a_s)
    b_mail |-> a_busy); // R2
  AST_PERR_IDLE_A: assert property (@(posedge clk_a) disable iff (!rst_a_s)
    !a_wr_en |-> a_perr_n); // R7
  AST_PERR_IDLE_B: assert property (@(posedge clk_b) disable iff (!rst_b_s)
    !b_wr_en |-> b_perr_n); // R7
  AST_GEN_B: assert property (@(posedge clk_b) disable iff (!rst_b_s)
    b_gen |-> lanes_match(b_rdata, b_odd)); // R9
  AST_GEN_A: assert property (@(posedge clk_a) disable iff (!rst_a_s)
    a_gen |-> lanes_match(a_rdata, a_odd)); // R9
endmodule

bind xmb_pair xmb_pair_chk #(.LANES(LANES), .LANE_DW(LANE_DW)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_a_s(rst_a_s), .rst_b_s(rst_b_s),
  .a_wr_en(a_wr_en), .b_wr_en(b_wr_en), .a_rd_en(a_rd_en), .b_rd_en(b_rd_en),
  .a_busy(a_busy), .b_busy(b_busy), .a_mail(a_mail), .b_mail(b_mail),
  .a_perr_n(a_perr_n), .b_perr_n(b_perr_n), .a_gen(a_gen), .b_gen(b_gen),
  .a_odd(a_odd), .b_odd(b_odd), .a_rdata(a_rdata), .b_rdata(b_rdata),
  .mb_ab_word(mb_ab_word), .mb_ba_word(mb_ba_word)
);

// File: tb/xmb_pair_tb.sv
module xmb_pair_tb;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int W = 36;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n;
  logic a_wr_en, a_rd_en, a_odd, a_gen, b_wr_en, b_rd_en, b_odd, b_gen;
  logic [W-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_mail, a_busy, a_perr_n, b_mail, b_busy, b_perr_n;
  logic rd_a_mon = 1'b0, rd_b_mon = 1'b0, rd_a_man, rd_b_man;
  bit mon_a_on = 0, mon_b_on = 0;
  int checks = 0, fails = 0;
  logic [W-1:0] exp_ab[$], exp_ba[$];
  string tag_ab[$], tag_ba[$];

  always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;
  assign a_rd_en = rd_a_mon | rd_a_man;
  assign b_rd_en = rd_b_mon | rd_b_man;

  xmb_pair u_dut (.*);

  function automatic logic [W-1:0] mk(input logic [31:0] d, input logic odd);
    logic [W-1:0] r;
    for (int l = 0; l < 4; l++) begin
      r[9*l +: 8] = d[8*l +: 8];
      r[9*l + 8]  = (^d[8*l +: 8]) ^ odd;
    end
    return r;
  endfunction

  function automatic logic [31:0] strip(input logic [W-1:0] w);
    logic [31:0] d;
    for (int l = 0; l < 4; l++) d[8*l +: 8] = w[9*l +: 8];
    return d;
  endfunction

  function automatic logic par_ok(input logic [W-1:0] w, input logic odd);
    logic ok = 1'b1;
    for (int l = 0; l < 4; l++) ok &= ((^w[9*l +: 9]) == odd);
    return ok;
  endfunction

  function automatic logic [W-1:0] view(input logic [W-1:0] w, input logic gen, input logic odd);
    return gen ? mk(strip(w), odd) : w;
  endfunction

  task automatic check(input bit cond, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: port B consumes A-to-B mail
  always @(negedge clk_b) begin
    if (rd_b_mon) begin
      rd_b_mon = 1'b0;
      check(b_mail == 1'b0, "R4 mail clears after read", W'(b_mail), '0);
    end else if (mon_b_on && b_mail) begin
      if (exp_ab.size() == 0) check(1'b0, "R2 unexpected mail at B", b_rdata, '0);
      else begin
        logic [W-1:0] e;
        string t;
        e = view(exp_ab.pop_front(), b_gen, b_odd);
        t = tag_ab.pop_front();
        check(b_rdata == e, t, b_rdata, e);
      end
      rd_b_mon = 1'b1;
    end
  end

  // monitor: port A consumes B-to-A mail
  always @(negedge clk_a) begin
    if (rd_a_mon) begin
      rd_a_mon = 1'b0;
      check(a_mail == 1'b0, "R5 mail clears after read at A", W'(a_mail), '0);
    end else if (mon_a_on && a_mail) begin
      if (exp_ba.size() == 0) check(1'b0, "R5 unexpected mail at A", a_rdata, '0);
      else begin
        logic [W-1:0] e;
        string t;
        e = view(exp_ba.pop_front(), a_gen, a_odd);
        t = tag_ba.pop_front();
        check(a_rdata == e, t, a_rdata, e);
      end
      rd_a_mon = 1'b1;
    end
  end

  task automatic write_a(input logic [W-1:0] w, input bit push, input string t);
    @(negedge clk_a);
    if (push) for (int i = 0; i < 200 && a_busy; i++) @(negedge clk_a);
    a_wr_en = 1'b1; a_wdata = w;
    #1 check(a_perr_n == par_ok(w, a_odd), "R7 port A parity flag", W'(a_perr_n), W'(par_ok(w, a_odd)));
    if (push) begin exp_ab.push_back(w); tag_ab.push_back(t); end
    @(negedge clk_a); a_wr_en = 1'b0;
    check(a_busy == 1'b1, "R3 busy after write", W'(a_busy), W'(1));
  endtask

  task automatic write_b(input logic [W-1:0] w, input string t);
    @(negedge clk_b);
    for (int i = 0; i < 200 && b_busy; i++) @(negedge clk_b);
    b_wr_en = 1'b1; b_wdata = w;
    #1 check(b_perr_n == par_ok(w, b_odd), "R7 port B parity flag", W'(b_perr_n), W'(par_ok(w, b_odd)));
    exp_ba.push_back(w); tag_ba.push_back(t);
    @(negedge clk_b); b_wr_en = 1'b0;
    check(b_busy == 1'b1, "R5 busy after write at B", W'(b_busy), W'(1));
  endtask

  task automatic drain;
    for (int i = 0; i < 400 && (exp_ab.size() != 0 || exp_ba.size() != 0); i++) @(negedge clk_b);
    repeat (10) @(negedge clk_a);
    check(a_busy == 1'b0, "R4 busy falls after read", W'(a_busy), '0);
    check(b_busy == 1'b0, "R5 busy falls after read", W'(b_busy), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_a);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_wr_en = 0; b_wr_en = 0; rd_a_man = 0; rd_b_man = 0;
    a_odd = 1; b_odd = 1; a_gen = 0; b_gen = 0;
    a_wdata = '0; b_wdata = '0;
    repeat (4) @(negedge clk_b);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_b);
    @(negedge clk_a);
    check(!a_mail && !b_mail, "R1 mail flags after reset", W'({a_mail, b_mail}), '0);
    check(!a_busy && !b_busy, "R1 busy after reset", W'({a_busy, b_busy}), '0);
    check(a_rdata == '0 && b_rdata == '0, "R1 read buses after reset", a_rdata | b_rdata, '0);

    // R6: read pulse without mail
    @(negedge clk_b); rd_b_man = 1; @(negedge clk_b); rd_b_man = 0;
    repeat (3) @(negedge clk_b);
    check(b_mail == 0, "R6 no mail after empty read", W'(b_mail), '0);
    @(negedge clk_a);
    check(a_busy == 0, "R6 writer idle after empty read", W'(a_busy), '0);

    // R2/R3: deliver with monitor held off, then try a write while busy
    write_a(mk(32'h1234_5678, 1), 1, "R2 R3 first word kept");
    begin
      int n = 0;
      while (!b_mail && n < 4) begin @(negedge clk_b); n++; end
      check(b_mail == 1, "R2 mail within four cycles", W'(b_mail), W'(1));
    end
    write_a(mk(32'hDEAD_BEEF, 1), 0, "");
    check(a_busy == 1, "R3 still busy after ignored write", W'(a_busy), W'(1));
    @(negedge clk_b);
    check(b_mail == 1, "R2 mail held until read", W'(b_mail), W'(1));
    mon_b_on = 1;
    drain();

    // R8/R10: assorted words, good and bad parity, both senses
    write_a(mk(32'h0000_0000, 1), 1, "R10 zero word");
    write_a(mk(32'hFFFF_FFFF, 1), 1, "R10 ones word");
    write_a(mk(32'hA5C3_0F81, 1) ^ 36'h0_0004_0000, 1, "R8 bad lane two");
    drain();
    a_odd = 0;
    write_a(mk(32'h8001_7E42, 0), 1, "R10 even sense");
    write_a(mk(32'h3C3C_3C3C, 1), 1, "R8 odd word under even check");
    drain();

    // R9: generation on at B, both senses
    b_gen = 1; b_odd = 0;
    write_a(mk(32'h1357_9BDF, 1), 1, "R9 even generation");
    drain();
    b_odd = 1;
    write_a(36'hF_0F0F_0F0F, 1, "R9 odd generation");
    drain();
    b_gen = 0;

    // R5: B to A direction
    mon_a_on = 1; b_odd = 1; a_odd = 1;
    write_b(mk(32'hCAFE_F00D, 1), "R5 B to A word");
    write_b(mk(32'h0102_0304, 1) ^ 36'h1_0000_0000, "R5 R8 bad parity B to A");
    drain();
    a_gen = 1; a_odd = 0;
    write_b(mk(32'h7777_0001, 1), "R5 R9 generation at A");
    drain();
    a_gen = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule